// File: doc/BRIEF.md
# Serial PCM Timeslot Cell Port

This block connects one T1 or E1 line to a stream of ATM cell bytes. The line side is a serial data pair (transmit and receive) plus a frame sync pulse that marks the start of each 125 µs frame. Bit timing is carried as a one-cycle bit strobe, so the whole port runs in a single system clock domain. The strobe is derived from the line bit clock, which runs at 2.048 Mb/s for E1 and 1.544 Mb/s for T1. On transmit, the port serialises cell bytes into the timeslots that may carry payload. In the reserved timeslots it releases the data line. On receive, it deserialises payload timeslots and presents whole bytes.

The port tracks its position in the frame with a counter. It locks to the first sync pulse it sees. After that it checks every pulse against the expected frame boundary. Both a pulse that arrives out of place and a pulse that is missing at the boundary set a sticky fault flag. Software clears the flag by writing a one, which appears here as a one-cycle clear input. The data line is modelled as a data bit and an output enable, and a pad outside the block makes the tri-state.

Top module: `pcm_cell_port`

## Requirements
- R1: After reset, `sync_lock_o`, `fault_o`, `tx_oe_o`, `tx_d_o`, `tx_ready_o` and `rx_valid_o` are all 0.
- R2: With `e1_mode_i`=1 a frame is 256 bit positions (32 timeslots of 8 bits, timeslot n at positions 8n..8n+7). Timeslots 0 and 16 are reserved: `tx_oe_o` is 0, no byte is taken and none is delivered. All other timeslots carry payload.
- R3: With `e1_mode_i`=0 a frame is 193 positions. Position 0 is the framing bit and is reserved. Timeslot n (0..23) occupies positions 8n+1..8n+8. When `t1_sig_slot_i`=1, timeslot 23 is also reserved.
- R4: The transmit line changes only on the clock edge that samples a strobe, and it then shows the bit for that strobe's frame position. Bytes go out MSB first. `tx_ready_o` is 1 together with the strobe of the first bit of each payload timeslot while locked, and the byte is taken there when `tx_valid_i` is 1. `tx_d_o` is 0 whenever `tx_oe_o` is 0.
- R5: If `tx_valid_i` is 0 when a payload timeslot starts, the idle byte 0x00 is sent in that timeslot.
- R6: `rx_d_i` is sampled with each strobe. One clock after the strobe of the last bit of a payload timeslot, `rx_valid_o` pulses for one clock, and `rx_data_o` holds that timeslot's 8 bits with the first received bit as the MSB.
- R7: A sync pulse while locked at any position other than the frame start sets `fault_o`. That strobe then becomes position 0 of a new frame.
- R8: A missing sync at the expected frame start sets `fault_o` and drops lock. While unlocked, `tx_oe_o` and `tx_ready_o` stay 0 and `rx_valid_o` does not pulse, until the next sync pulse.
- R9: `fault_o` is sticky. A `fault_clr_i` pulse clears it on the next clock, but a fault event in the same clock wins over the clear.
- R10: A sync pulse while unlocked locks the port (`sync_lock_o`=1) at position 0 without setting `fault_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| e1_mode_i | input | 1 | 1: 32-timeslot frame, 0: 24-timeslot frame |
| t1_sig_slot_i | input | 1 | Reserve the last T1 timeslot for signalling |
| bit_en_i | input | 1 | One-cycle strobe per line bit |
| sync_i | input | 1 | Frame sync, sampled with the strobe |
| fault_clr_i | input | 1 | Clears the sticky fault flag |
| tx_data_i | input | 8 | Cell byte to send |
| tx_valid_i | input | 1 | `tx_data_i` holds a byte |
| tx_ready_o | output | 1 | Byte taken in this clock |
| tx_d_o | output | 1 | Transmit line data |
| tx_oe_o | output | 1 | Transmit line drive enable |
| rx_d_i | input | 1 | Receive line data |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | Received byte valid (one clock) |
| sync_lock_o | output | 1 | Frame position is locked |
| fault_o | output | 1 | Sticky sync fault |

## Verification
The bench runs a reference model of frame position and lock over long random runs in both frame formats, with the signalling timeslot on and off. A slot map that is off by one would enable the line during a reserved timeslot, or shift every T1 byte against the framing bit. The directed cases cover three situations: a sync pulse that arrives early, a frame whose sync is missing, and a fault event in the same clock as a clear. A port that did not re-anchor on an early pulse would keep the old phase. One that held lock after a missing pulse would keep transmitting. One that let the clear win would lose a fault. Gaps in `tx_valid_i` check that the idle byte is sent rather than the previous byte.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  localparam int SLOT_W_D   = 8;
  localparam int E1_SLOTS_D = 32;
  localparam int T1_SLOTS_D = 24;

  typedef struct packed {
    logic payload;
    logic first;
    logic last;
  } slot_info_t;
endpackage

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer #(
  parameter int SLOT_W   = 8,
  parameter int E1_SLOTS = 32,
  parameter int T1_SLOTS = 24,
  localparam int POS_W   = $clog2(E1_SLOTS * SLOT_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             e1_mode_i,
  input  logic             bit_en_i,
  input  logic             sync_i,
  input  logic             fault_clr_i,
  output logic [POS_W-1:0] pos_nxt_o,
  output logic             lock_nxt_o,
  output logic             lock_o,
  output logic             fault_o
);
  localparam int E1_LAST = E1_SLOTS * SLOT_W - 1;
  localparam int T1_LAST = T1_SLOTS * SLOT_W;  // framing bit adds one position

  logic [POS_W-1:0] pos_q, last_pos;
  logic             lock_q, fault_q, fault_set, at_end;

  assign last_pos = e1_mode_i ? POS_W'(E1_LAST) : POS_W'(T1_LAST);
  assign at_end   = (pos_q == last_pos);

  always_comb begin
    pos_nxt_o  = pos_q;
    lock_nxt_o = lock_q;
    fault_set  = 1'b0;
    if (bit_en_i) begin
      if (sync_i) begin
        fault_set  = lock_q && !at_end;  // early pulse
        pos_nxt_o  = '0;
        lock_nxt_o = 1'b1;
      end else if (lock_q) begin
        if (at_end) begin                // pulse missing at boundary
          fault_set  = 1'b1;
          lock_nxt_o = 1'b0;
          pos_nxt_o  = '0;
        end else begin
          pos_nxt_o = pos_q + POS_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q   <= '0;
      lock_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      pos_q  <= pos_nxt_o;
      lock_q <= lock_nxt_o;
      if (fault_set)        fault_q <= 1'b1;
      else if (fault_clr_i) fault_q <= 1'b0;
    end
  end

  assign lock_o  = lock_q;
  assign fault_o = fault_q;
endmodule

// File: rtl/pcm_slot_map.sv
module pcm_slot_map
  import pcm_port_pkg::*;
#(
  parameter int SLOT_W   = 8,
  parameter int E1_SLOTS = 32,
  parameter int T1_SLOTS = 24,
  parameter logic [E1_SLOTS-1:0] E1_RSV_MASK = E1_SLOTS'((64'd1 << 16) | 64'd1),
  localparam int POS_W   = $clog2(E1_SLOTS * SLOT_W),
  localparam int BIT_W   = $clog2(SLOT_W),
  localparam int SIDX_W  = POS_W - BIT_W
) (
  input  logic             e1_mode_i,
  input  logic             t1_sig_slot_i,
  input  logic [POS_W-1:0] pos_i,
  output slot_info_t       info_o
);
  logic [POS_W-1:0]  rel;
  logic [SIDX_W-1:0] slot;
  logic [BIT_W-1:0]  bidx;

  // T1 positions are offset by the framing bit
  assign rel  = e1_mode_i ? pos_i : pos_i - POS_W'(1);
  assign slot = rel[POS_W-1:BIT_W];
  assign bidx = rel[BIT_W-1:0];

  always_comb begin
    if (e1_mode_i) begin
      info_o.payload = !E1_RSV_MASK[slot];
    end else begin
      info_o.payload = (pos_i != '0) &&
                       !(t1_sig_slot_i && (slot == SIDX_W'(T1_SLOTS - 1)));
    end
    info_o.first = (bidx == '0);
    info_o.last  = (bidx == BIT_W'(SLOT_W - 1));
  end
endmodule

// File: rtl/pcm_tx_ser.sv
module pcm_tx_ser
  import pcm_port_pkg::*;
#(
  parameter int SLOT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              lock_nxt_i,
  input  slot_info_t        info_i,
  input  logic [SLOT_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic              tx_d_o,
  output logic              tx_oe_o
);
  logic [SLOT_W-1:0] sh_q, load_byte;
  logic              active, take;

  assign active     = bit_en_i && lock_nxt_i && info_i.payload;
  assign take       = active && info_i.first;
  assign tx_ready_o = take;
  assign load_byte  = tx_valid_i ? tx_data_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      tx_d_o  <= 1'b0;
      tx_oe_o <= 1'b0;
    end else if (bit_en_i) begin
      tx_oe_o <= active;
      if (take) begin
        tx_d_o <= load_byte[SLOT_W-1];
        sh_q   <= load_byte << 1;
      end else if (active) begin
        tx_d_o <= sh_q[SLOT_W-1];
        sh_q   <= sh_q << 1;
      end else begin
        tx_d_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pcm_rx_deser.sv
module pcm_rx_deser
  import pcm_port_pkg::*;
#(
  parameter int SLOT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              lock_nxt_i,
  input  slot_info_t        info_i,
  input  logic              rx_d_i,
  output logic [SLOT_W-1:0] rx_data_o,
  output logic              rx_valid_o
);
  logic [SLOT_W-1:0] sh_q, sh_nxt;
  logic              active;

  assign active = bit_en_i && lock_nxt_i && info_i.payload;
  assign sh_nxt = {sh_q[SLOT_W-2:0], rx_d_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q       <= '0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      if (active) begin
        sh_q <= sh_nxt;
        if (info_i.last) begin
          rx_data_o  <= sh_nxt;
          rx_valid_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pcm_cell_port.sv
module pcm_cell_port
  import pcm_port_pkg::*;
#(
  parameter int SLOT_W   = SLOT_W_D,
  parameter int E1_SLOTS = E1_SLOTS_D,
  parameter int T1_SLOTS = T1_SLOTS_D,
  localparam int POS_W   = $clog2(E1_SLOTS * SLOT_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              e1_mode_i,
  input  logic              t1_sig_slot_i,
  input  logic              bit_en_i,
  input  logic              sync_i,
  input  logic              fault_clr_i,
  input  logic [SLOT_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic              tx_d_o,
  output logic              tx_oe_o,
  input  logic              rx_d_i,
  output logic [SLOT_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              sync_lock_o,
  output logic              fault_o
);
  logic [POS_W-1:0] pos_nxt;
  logic             lock_nxt;
  slot_info_t       info;

  pcm_frame_timer #(
    .SLOT_W(SLOT_W), .E1_SLOTS(E1_SLOTS), .T1_SLOTS(T1_SLOTS)
  ) timer_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .e1_mode_i(e1_mode_i),
    .bit_en_i(bit_en_i), .sync_i(sync_i), .fault_clr_i(fault_clr_i),
    .pos_nxt_o(pos_nxt), .lock_nxt_o(lock_nxt),
    .lock_o(sync_lock_o), .fault_o(fault_o)
  );

  pcm_slot_map #(
    .SLOT_W(SLOT_W), .E1_SLOTS(E1_SLOTS), .T1_SLOTS(T1_SLOTS)
  ) map_i (
    .e1_mode_i(e1_mode_i), .t1_sig_slot_i(t1_sig_slot_i),
    .pos_i(pos_nxt), .info_o(info)
  );

  pcm_tx_ser #(.SLOT_W(SLOT_W)) tx_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i),
    .lock_nxt_i(lock_nxt), .info_i(info),
    .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i),
    .tx_ready_o(tx_ready_o), .tx_d_o(tx_d_o), .tx_oe_o(tx_oe_o)
  );

  pcm_rx_deser #(.SLOT_W(SLOT_W)) rx_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i),
    .lock_nxt_i(lock_nxt), .info_i(info), .rx_d_i(rx_d_i),
    .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o)
  );
endmodule

// File: rtl/pcm_cell_port_chk.sv
module pcm_cell_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_en_i,
  input logic fault_clr_i,
  input logic tx_ready_o,
  input logic tx_d_o,
  input logic tx_oe_o,
  input logic rx_valid_o,
  input logic sync_lock_o,
  input logic fault_o
);
  a_r4_ready_with_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> bit_en_i);

  a_r4_idle_line_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_oe_o |-> !tx_d_o);

  a_r8_drive_needs_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_oe_o |-> sync_lock_o);

  a_r4_hold_between_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> ($stable(tx_oe_o) && $stable(tx_d_o) && $stable(sync_lock_o)));

  a_r6_rx_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  a_r9_fault_falls_on_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fault_o) |-> $past(fault_clr_i));

  a_r9_fault_rises_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> $past(bit_en_i));
endmodule

bind pcm_cell_port pcm_cell_port_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i), .fault_clr_i(fault_clr_i),
  .tx_ready_o(tx_ready_o), .tx_d_o(tx_d_o), .tx_oe_o(tx_oe_o),
  .rx_valid_o(rx_valid_o), .sync_lock_o(sync_lock_o), .fault_o(fault_o)
);

// File: tb/pcm_cell_port_tb_top.sv
module pcm_cell_port_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       e1_mode_i = 1'b1, t1_sig_slot_i = 1'b0;
  logic       bit_en_i = 1'b0, sync_i = 1'b0, fault_clr_i = 1'b0;
  logic [7:0] tx_data_i = '0;
  logic       tx_valid_i = 1'b0, rx_d_i = 1'b0;
  logic       tx_ready_o, tx_d_o, tx_oe_o, rx_valid_o, sync_lock_o, fault_o;
  logic [7:0] rx_data_o;

  always #4 clk_i = ~clk_i;

  pcm_cell_port dut_i (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  bit         m_lock, m_fault, m_e1, m_sig;
  int         m_pos;
  logic [7:0] m_tx, m_rx;
  bit         m_idle;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int last_pos(bit e1);
    return e1 ? 255 : 192;
  endfunction

  function automatic bit is_pay(int p, bit e1, bit sig);
    int s;
    if (e1) begin
      s = p / 8;
      return (s != 0) && (s != 16);
    end
    if (p == 0) return 0;
    s = (p - 1) / 8;
    return !(sig && s == 23);
  endfunction

  function automatic int bit_idx(int p, bit e1);
    return e1 ? p % 8 : (p - 1) % 8;
  endfunction

  task automatic do_reset(bit e1, bit sig);
    @(negedge clk_i);
    rst_ni = 1'b0; e1_mode_i = e1; t1_sig_slot_i = sig;
    m_e1 = e1; m_sig = sig; m_lock = 0; m_fault = 0; m_pos = 0; m_tx = 0; m_rx = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 lock", sync_lock_o, 0);
    chk("R1 fault", fault_o, 0);
    chk("R1 oe", tx_oe_o, 0);
    chk("R1 d", tx_d_o, 0);
    chk("R1 rvalid", rx_valid_o, 0);
    chk("R1 ready", tx_ready_o, 0);
  endtask

  task automatic strobe(bit sy, bit clr, string ftag);
    bit rb, v, pay, e_rdy, e_d, e_rv;
    logic [7:0] dat, byt;
    int bi;
    @(negedge clk_i);
    rb = 1'($urandom); v = ($urandom % 10) < 7; dat = 8'($urandom);
    bit_en_i = 1; sync_i = sy; rx_d_i = rb; tx_valid_i = v; tx_data_i = dat;
    fault_clr_i = clr;
    // model
    if (sy) begin
      if (m_lock && m_pos != last_pos(m_e1)) m_fault = 1;
      else if (clr) m_fault = 0;
      m_pos = 0; m_lock = 1;
    end else if (m_lock) begin
      if (m_pos == last_pos(m_e1)) begin
        m_fault = 1; m_lock = 0; m_pos = 0;
      end else begin
        m_pos++;
        if (clr) m_fault = 0;
      end
    end else if (clr) m_fault = 0;
    pay = m_lock && is_pay(m_pos, m_e1, m_sig);
    bi = bit_idx(m_pos, m_e1);
    e_rdy = pay && bi == 0;
    e_rv = 0;
    if (e_rdy) begin
      byt = v ? dat : 8'h00; m_idle = !v;
      e_d = byt[7]; m_tx = byt << 1;
    end else if (pay) begin
      e_d = m_tx[7]; m_tx = m_tx << 1;
    end else e_d = 0;
    if (pay) begin
      m_rx = {m_rx[6:0], rb};
      e_rv = (bi == 7);
    end
    #1;
    chk(m_e1 ? "R2 ready" : "R3 ready", tx_ready_o, e_rdy);
    @(negedge clk_i);
    bit_en_i = 0; sync_i = 0; fault_clr_i = 0; tx_valid_i = 0;
    chk(m_e1 ? "R2 oe" : "R3 oe", tx_oe_o, pay);
    chk(m_idle && pay ? "R5 idle bit" : "R4 bit", tx_d_o, e_d);
    chk("R6 rvalid", rx_valid_o, e_rv);
    if (e_rv) chk("R6 rdata", rx_data_o, m_rx);
    chk(ftag, fault_o, m_fault);
    chk("R10 lock", sync_lock_o, m_lock);
    @(negedge clk_i);
    chk("R6 pulse", rx_valid_o, 0);
    chk("R4 hold oe", tx_oe_o, pay);
  endtask

  task automatic frames(int n, string ftag);
    for (int f = 0; f < n; f++)
      for (int p = 0; p <= last_pos(m_e1); p++) strobe(p == 0, 0, ftag);
  endtask

  task automatic finish_frame(string ftag);
    while (m_pos != last_pos(m_e1)) strobe(0, 0, ftag);
  endtask

  task automatic clear_fault();
    @(negedge clk_i); fault_clr_i = 1;
    @(negedge clk_i); fault_clr_i = 0; m_fault = 0;
    chk("R9 cleared", fault_o, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    // E1 lock and payload mapping
    do_reset(1, 0);
    strobe(0, 0, "R8 unlocked");
    frames(3, "R10 no fault");
    // early sync
    repeat (50) strobe(0, 0, "R2 fault");
    strobe(1, 0, "R7 early");
    finish_frame("R7 sticky");
    frames(1, "R9 sticky");
    clear_fault();
    // missing sync
    for (int p = 0; p <= last_pos(m_e1); p++) strobe(0, 0, "R8 missing");
    repeat (20) strobe(0, 0, "R8 unlocked");
    frames(2, "R8 relock");
    clear_fault();
    // fault event in the same clock as a clear
    finish_frame("R9 pre");
    strobe(0, 1, "R9 set wins");
    clear_fault();
    frames(1, "R10 relock");
    // random sync disturbances
    for (int i = 0; i < 600; i++) strobe(($urandom % 100) == 0 || m_pos == last_pos(m_e1), ($urandom % 50) == 0, "R7 random");
    // T1 without and with signalling slot
    do_reset(0, 0);
    frames(2, "R3 t1");
    do_reset(0, 1);
    frames(2, "R3 t1 sig");
    strobe(1, 0, "R7 t1");
    repeat (30) strobe(0, 0, "R7 t1 early");
    strobe(1, 0, "R7 t1 early");
    finish_frame("R7 t1");
    frames(1, "R3 t1");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule